// File: doc/BRIEF.md
# External Conversion Trigger Unit

This block sits in front of the sequence controller of a multi-channel sampling converter and decides when a conversion sequence begins. It takes an asynchronous trigger pin, brings it into the bus clock domain through a parameterised flip-flop chain, and qualifies it by the configured sensitivity. The sensitivity can be a rising edge, a falling edge, a low level or a high level. When the external trigger is disabled, sequences start on a software start strobe instead. They run either once or back to back, as chosen by the scan bit.

The unit issues a one-cycle start pulse to the sequence controller and watches the controller's busy indication. In edge mode it records a sticky overrun flag when another active edge arrives while a sequence is still running. In level mode a held trigger relaunches a sequence as soon as the previous one ends, and a level that drops and returns during a sequence is not an error. The overrun flag is cleared by software writing 1 to it, by any write to the control registers that aborts a sequence, and by a write to the start register.

Top module: `ext_trig_unit`

## Requirements
- R1: The sensitivity is coded as {cfg_level, cfg_pol}: 00 falling edge, 01 rising edge, 10 low level, 11 high level. When the trigger is enabled and the unit is idle, a qualifying change on trig_pin that occurs after clock edge c gives a one-cycle seq_start pulse after clock edge c + SYNC_STAGES + 1.
- R2: When cfg_en is 0 and cfg_scan is 0, a wr_start strobe gives exactly one seq_start pulse on the next clock edge, and nothing follows when the sequence ends. While cfg_en is 0, activity on trig_pin starts nothing.
- R3: When cfg_en is 0 and cfg_scan is 1, a wr_start strobe starts a sequence on the next clock edge. After that, a new seq_start is issued one cycle after each time seq_busy drops. This continues until a wr_ctl strobe.
- R4: When cfg_en is 1, wr_start never produces a seq_start pulse.
- R5: In edge mode with the unit idle, each active edge starts exactly one sequence, and an inactive edge starts none. While seq_busy is high, no sequence is started.
- R6: In edge mode, an active edge seen while a sequence is pending or running sets overrun and does not start a sequence. The flag stays set until it is cleared.
- R7: In level mode, overrun is never set. This holds even when the trigger falls away and comes back during a sequence.
- R8: In level mode, if the trigger is still at its active level when seq_busy drops, the next seq_start follows one cycle later.
- R9: A wr_clr_ovr, wr_ctl or wr_start strobe clears overrun on the next clock edge. If an overrun condition arises in the same cycle as one of these strobes, the flag is set.
- R10: A change of cfg_level, cfg_pol or cfg_en does not by itself count as an active edge. This holds even when the change turns the synchronised pin state from inactive to active.
- R11: While rst_n is low, seq_start and overrun are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| seq_busy | input | 1 | High while the controller runs a sequence; rises the cycle after seq_start |
| cfg_level | input | 1 | 1 selects level sensitivity, 0 selects edge sensitivity |
| cfg_pol | input | 1 | 1 selects high/rising, 0 selects low/falling |
| cfg_en | input | 1 | Enables the external trigger |
| cfg_scan | input | 1 | Continuous sequences when the trigger is disabled |
| wr_ctl | input | 1 | Strobe: write to an aborting control register |
| wr_start | input | 1 | Strobe: write to the start register |
| wr_clr_ovr | input | 1 | Strobe: software writes 1 to the overrun flag |
| seq_start | output | 1 | One-cycle sequence start request |
| overrun | output | 1 | Sticky edge-mode overrun flag |

## Verification
The bench builds the unit with SYNC_STAGES set to 3 rather than the default of 2. This makes every expected start cycle depend on the chain length, so a synchroniser that drops or adds a stage is caught. The controller is modelled with a fixed six-cycle busy window. This puts the level-mode glitch, the edge-mode overrun edge and the clear strobe that coincides with a set all inside a single sequence, each at a precisely known cycle.

// File: rtl/trig_unit_pkg.sv
package trig_unit_pkg;

    typedef struct packed {
        logic level;
        logic pol;
        logic en;
    } trig_cfg_t;

    typedef struct packed {
        trig_cfg_t cfg;
        logic      hist;
    } qual_state_t;

    typedef struct packed {
        logic start;
        logic ovr;
        logic run;
    } arb_state_t;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] chain_d;
    logic [MSB:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_chain
            always_comb chain_d = {chain_q[MSB-1:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[MSB];

endmodule

// File: rtl/trig_qualify.sv
module trig_qualify
    import trig_unit_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trig_s,
    input  trig_cfg_t cfg,
    output logic      edge_hit,
    output logic      go
);
    qual_state_t q;
    qual_state_t d;
    logic        active;
    logic        cfg_chg;

    // Polarity folds the pin into one "active" sense; history is kept in
    // that sense so a config change must mask the comparison for a cycle.
    always_comb begin
        active   = cfg.pol ? trig_s : ~trig_s;
        cfg_chg  = (cfg != q.cfg);
        edge_hit = active & ~q.hist & ~cfg_chg;
        go       = cfg.level ? active : edge_hit;
        d.cfg    = cfg;
        d.hist   = active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_CFG_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != q.cfg) |-> !edge_hit) else $error("cfg change made an edge"); // R10

endmodule

// File: rtl/trig_arbiter.sv
module trig_arbiter
    import trig_unit_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trig_cfg_t cfg,
    input  logic      scan,
    input  logic      go,
    input  logic      edge_hit,
    input  logic      seq_busy,
    input  logic      wr_ctl,
    input  logic      wr_start,
    input  logic      wr_clr,
    output logic      start,
    output logic      ovr
);
    arb_state_t q;
    arb_state_t d;
    logic       busy_eff;
    logic       ovr_set;
    logic       ovr_clr;

    always_comb begin
        // The controller raises busy one cycle after the pulse; the pulse
        // itself covers that gap.
        busy_eff = seq_busy | q.start;
        d        = q;

        d.run = wr_ctl ? 1'b0 : (wr_start ? scan : q.run);
        d.run = d.run & scan;

        if (cfg.en) begin
            d.start = go & ~busy_eff & ~wr_ctl;
            d.run   = 1'b0;
        end else begin
            d.start = wr_start | (q.run & scan & ~busy_eff & ~wr_ctl);
        end

        ovr_set = cfg.en & ~cfg.level & edge_hit & busy_eff;
        ovr_clr = wr_clr | wr_ctl | wr_start;
        d.ovr   = ovr_set | (q.ovr & ~ovr_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start = q.start;
    assign ovr   = q.ovr;

    AST_SINGLE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.en && !scan && !wr_start) |=> !q.start) else $error("extra start"); // R2
    AST_SW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !go) |=> !q.start) else $error("start without trigger"); // R4
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && seq_busy) |=> !q.start) else $error("start while busy"); // R5
    AST_EDGE_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !cfg.level && edge_hit && (seq_busy || q.start)) |=> q.ovr)
        else $error("overrun missed"); // R6
    AST_LEVEL_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ovr && !(cfg.en && !cfg.level)) |=> !q.ovr) else $error("level overrun"); // R7
    AST_LEVEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && cfg.level && go && !seq_busy && !q.start && !wr_ctl) |=> q.start)
        else $error("level restart missed"); // R8
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_clr || wr_ctl || wr_start) && !edge_hit) |=> !q.ovr) else $error("clear missed"); // R9

endmodule

// File: rtl/ext_trig_unit.sv
module ext_trig_unit
    import trig_unit_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_pin,
    input  logic seq_busy,
    input  logic cfg_level,
    input  logic cfg_pol,
    input  logic cfg_en,
    input  logic cfg_scan,
    input  logic wr_ctl,
    input  logic wr_start,
    input  logic wr_clr_ovr,
    output logic seq_start,
    output logic overrun
);
    trig_cfg_t cfg;
    logic      trig_s;
    logic      edge_hit;
    logic      go;

    always_comb begin
        cfg.level = cfg_level;
        cfg.pol   = cfg_pol;
        cfg.en    = cfg_en;
    end

    trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (trig_pin),
        .dout (trig_s)
    );

    trig_qualify qual_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_s  (trig_s),
        .cfg     (cfg),
        .edge_hit(edge_hit),
        .go      (go)
    );

    trig_arbiter arb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .scan    (cfg_scan),
        .go      (go),
        .edge_hit(edge_hit),
        .seq_busy(seq_busy),
        .wr_ctl  (wr_ctl),
        .wr_start(wr_start),
        .wr_clr  (wr_clr_ovr),
        .start   (seq_start),
        .ovr     (overrun)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!seq_start && !overrun)) else $error("outputs active in reset"); // R11

endmodule

// File: tb/ext_trig_unit_tb_top.sv
`timescale 1ns/1ps
module ext_trig_unit_tb_top;
    localparam int SYNC     = 3;
    localparam int LAT      = SYNC + 1;
    localparam int BUSY_LEN = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_pin = 1'b0;
    logic cfg_level = 1'b0, cfg_pol = 1'b0, cfg_en = 1'b0, cfg_scan = 1'b0;
    logic wr_ctl = 1'b0, wr_start = 1'b0, wr_clr_ovr = 1'b0;
    logic seq_start, overrun, seq_busy;

    int cyc = 0;
    int busy_cnt = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int    exp_cyc[$];
    string exp_tag[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // controller model: busy for BUSY_LEN cycles from the cycle after the pulse
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)              busy_cnt <= 0;
        else if (seq_start)      busy_cnt <= BUSY_LEN;
        else if (busy_cnt != 0)  busy_cnt <= busy_cnt - 1;
    end
    assign seq_busy = (busy_cnt != 0);

    ext_trig_unit #(.SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .seq_busy(seq_busy),
        .cfg_level(cfg_level), .cfg_pol(cfg_pol), .cfg_en(cfg_en), .cfg_scan(cfg_scan),
        .wr_ctl(wr_ctl), .wr_start(wr_start), .wr_clr_ovr(wr_clr_ovr),
        .seq_start(seq_start), .overrun(overrun)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_start(input int at, input string tag);
        exp_cyc.push_back(at);
        exp_tag.push_back(tag);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: overrun/output got %0b expected %0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            while (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
                n_cmp++; n_bad++;
                $display("FAIL %s: seq_start got none expected pulse at cycle %0d", exp_tag[0], exp_cyc[0]);
                void'(exp_cyc.pop_front());
                void'(exp_tag.pop_front());
            end
            if (seq_start) begin
                n_cmp++;
                if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
                    void'(exp_cyc.pop_front());
                    void'(exp_tag.pop_front());
                end else begin
                    n_bad++;
                    $display("FAIL R2/R4/R5/R6/R10: seq_start got pulse at cycle %0d expected none", cyc);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run got hung expected finish");
        summary();
        $finish;
    end

    initial begin
        int c;
        // R11: reset state
        step(2);
        chk("R11", seq_start, 1'b0);
        chk("R11", overrun, 1'b0);
        step(2);
        rst_n = 1'b1;
        step(2);

        // R2: single software start, pin ignored while disabled
        c = cyc; wr_start = 1'b1; expect_start(c + 1, "R2");
        step(1); wr_start = 1'b0;
        step(5); trig_pin = 1'b1; step(6); trig_pin = 1'b0; step(15);

        // R3: continuous scan until an aborting write
        cfg_scan = 1'b1; step(1);
        c = cyc; wr_start = 1'b1;
        expect_start(c + 1, "R3"); expect_start(c + 9, "R3"); expect_start(c + 17, "R3");
        step(1); wr_start = 1'b0;
        step(19); wr_ctl = 1'b1;
        step(1); wr_ctl = 1'b0; cfg_scan = 1'b0;
        step(15);

        // R4 / R5: rising edge mode, software start ignored
        cfg_en = 1'b1; cfg_pol = 1'b1; cfg_level = 1'b0; step(5);
        wr_start = 1'b1; step(1); wr_start = 1'b0; step(10);
        c = cyc; trig_pin = 1'b1; expect_start(c + LAT, "R5");
        step(1); trig_pin = 1'b0; step(20);
        chk("R5", overrun, 1'b0);

        // R6: second rising edge inside the sequence
        c = cyc; trig_pin = 1'b1; expect_start(c + LAT, "R6");
        step(1); trig_pin = 1'b0; step(1); trig_pin = 1'b1;
        step(6);
        chk("R6", overrun, 1'b1);
        step(10);
        chk("R6", overrun, 1'b1);
        wr_clr_ovr = 1'b1; step(1); wr_clr_ovr = 1'b0;
        chk("R9", overrun, 1'b0);

        // R9: set wins over a coincident clear; then clear by wr_ctl
        trig_pin = 1'b0; step(8);
        c = cyc; trig_pin = 1'b1; expect_start(c + LAT, "R9");
        step(1); trig_pin = 1'b0; step(1); trig_pin = 1'b1;
        step(3); wr_clr_ovr = 1'b1;
        step(1); wr_clr_ovr = 1'b0;
        chk("R9", overrun, 1'b1);
        step(10); wr_ctl = 1'b1; step(1); wr_ctl = 1'b0;
        chk("R9", overrun, 1'b0);

        // R9 / R4: clear by wr_start without a start
        trig_pin = 1'b0; step(8);
        c = cyc; trig_pin = 1'b1; expect_start(c + LAT, "R6");
        step(1); trig_pin = 1'b0; step(1); trig_pin = 1'b1;
        step(6);
        chk("R6", overrun, 1'b1);
        step(6); wr_start = 1'b1; step(1); wr_start = 1'b0;
        chk("R9", overrun, 1'b0);
        step(10);

        // R1: falling edge code 00, rising pin is inactive
        cfg_pol = 1'b0; step(8);
        c = cyc; trig_pin = 1'b0; expect_start(c + LAT, "R1");
        step(15); trig_pin = 1'b1; step(12);

        // R1: low level code 10, pulse shorter than one sequence
        cfg_level = 1'b1; step(5);
        c = cyc; trig_pin = 1'b0; expect_start(c + LAT, "R1");
        step(5); trig_pin = 1'b1; step(15);

        // R7 / R8: high level code 11 with a glitch inside the sequence
        cfg_en = 1'b0; trig_pin = 1'b0; step(6);
        cfg_pol = 1'b1; cfg_en = 1'b1; step(5);
        c = cyc; trig_pin = 1'b1;
        expect_start(c + LAT, "R8"); expect_start(c + LAT + 8, "R8");
        step(LAT + 1); trig_pin = 1'b0;
        step(1); trig_pin = 1'b1;
        step(7); trig_pin = 1'b0;
        step(20);
        chk("R7", overrun, 1'b0);

        // R10: configuration changes that flip the active sense
        cfg_level = 1'b0; cfg_pol = 1'b0; step(10);
        trig_pin = 1'b1; step(10);
        cfg_pol = 1'b1; step(12);
        c = cyc; trig_pin = 1'b0; step(3); trig_pin = 1'b1;
        expect_start(c + 3 + LAT, "R10");
        step(15);
        chk("R10", overrun, 1'b0);

        step(5);
        while (exp_cyc.size() > 0) begin
            n_cmp++; n_bad++;
            $display("FAIL %s: seq_start got none expected pulse at cycle %0d", exp_tag[0], exp_cyc[0]);
            void'(exp_cyc.pop_front());
            void'(exp_tag.pop_front());
        end
        summary();
        $finish;
    end

endmodule